// File: doc/BRIEF.md
# Transceiver Reset Sequencer with Status Qualification and Retry

This block owns the active-low reset line of an external transceiver device. On a start request it pulls the reset line low and keeps it low for a minimum hold time. It then waits until the device's reference clocks are reported stable and waits a further settle time before it releases the line. After release it allows a long boot interval for the device's internal timers and a short interval for the serial link to settle. It then inspects a status word read back from the device.

The status word passes when both "timer expired" indications are set and no out-of-lock indication is set. On a pass the block ends the run. On a failure it asserts the reset line again and repeats the whole run. There is a fixed budget of attempts. When the last attempt fails, the block reports failure. The end of each run is marked by a one-cycle done pulse. A pass/fail flag remains valid until the next start request.

Every interval is given in microseconds and converted to clock cycles from a clock-frequency parameter, rounding up. The clock-stable indication and the status word may come from another clock domain, so they pass through a configurable synchroniser.

Top module: `xcvr_rst_seq`

## Requirements
- R1: While the block reset is active, and afterwards until the first start request, `dev_rst_n_o` is 0, `done_o` is 0 and `pass_o` is 0.
- R2: A start request sampled while idle drives `dev_rst_n_o` to 0 and `pass_o` to 0 in the next cycle.
- R3: On each attempt `dev_rst_n_o` stays 0 for HOLD cycles. It then stays 0 until the synchronised clock-stable input is seen high (at least one cycle), and for SETTLE cycles more. Only then is it released.
- R4: After release, the status word is evaluated at the clock edge that ends BOOT + LINK + 1 cycles of high `dev_rst_n_o`.
- R5: The status word passes only if bit ANA_BIT (default 0) is 1, bit PLL_BIT (default 1) is 1, and every bit selected by LOCK_MASK (default bits 7:4) is 0. Bits outside these positions have no effect.
- R6: On a pass, `done_o` is high for exactly one cycle and `pass_o` goes to 1 in that same cycle. `pass_o` stays 1 and `dev_rst_n_o` stays 1 until the next start request.
- R7: On a failed evaluation with attempts left, `dev_rst_n_o` returns to 0 in the next cycle and a new attempt begins. At most MAX_TRIES (default 3) attempts are made per start request.
- R8: When the final attempt fails, `done_o` pulses for one cycle with `pass_o` = 0, and `dev_rst_n_o` stays 1.
- R9: A start request that arrives while a run is in progress has no effect on the run.
- R10: Each interval in cycles is ceil(CLK_HZ × microseconds / 1,000,000). The defaults are HOLD 1000 µs, SETTLE 1000 µs, BOOT 15000 µs and LINK 200 µs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| start_i | input | 1 | Request to run a reset sequence |
| clk_stable_i | input | 1 | Device reference clocks are stable |
| dev_status_i | input | STAT_W | Status word read from the device |
| dev_rst_n_o | output | 1 | Active-low reset to the device |
| done_o | output | 1 | One-cycle pulse at the end of a run |
| pass_o | output | 1 | Result of the last run, 1 = success |

## Verification
All outputs are registered, so every output changes in the cycle after the edge that decides it. The reset line falls one cycle after start is sampled. The line rises HOLD + SETTLE + 1 cycles later when the clock-stable input is already stable. `done_o` and `pass_o` follow BOOT + LINK + 1 cycles after the release. The clock-stable input and the status word are seen SYNC_STAGES cycles late. The bench therefore keeps a history of the inputs it drove and looks SYNC_STAGES edges back when it decides a wait exit or a pass. It then compares all three outputs on every falling edge, so each result is checked in the exact cycle it is due. Separate counters measure the low and high widths of the reset line and the number of releases per run.

// File: rtl/xrs_pkg.sv
`timescale 1ns/1ps
package xrs_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HOLD,
      ST_WAIT_CLK,
      ST_SETTLE,
      ST_BOOT,
      ST_LINK,
      ST_CHECK
   } seq_state_e;

   // microseconds to clock cycles, rounded up to a whole cycle
   function automatic longint unsigned us_to_cycles(longint unsigned hz,
                                                    longint unsigned us);
      return (hz * us + 64'd999_999) / 64'd1_000_000;
   endfunction

endpackage

// File: rtl/xrs_sync.sv
`timescale 1ns/1ps
module xrs_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q_o = d_i;
      end else begin : g_chain
         logic [W-1:0] pipe [STAGES];
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) begin
               for (int i = 0; i < int'(STAGES); i++) pipe[i] <= '0;
            end else begin
               pipe[0] <= d_i;
               for (int i = 1; i < int'(STAGES); i++) pipe[i] <= pipe[i-1];
            end
         end
         assign q_o = pipe[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/xrs_timer.sv
`timescale 1ns/1ps
module xrs_timer #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   output logic             expired_o
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)             cnt_q <= '0;
      else if (load_i)         cnt_q <= load_val_i;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/xrs_status_chk.sv
`timescale 1ns/1ps
module xrs_status_chk #(
   parameter int unsigned STAT_W = 8,
   parameter int unsigned ANA_BIT = 0,
   parameter int unsigned PLL_BIT = 1,
   parameter logic [STAT_W-1:0] LOCK_MASK = 8'hF0
) (
   input  logic [STAT_W-1:0] status_i,
   output logic              ok_o
);

   generate
      if (ANA_BIT >= STAT_W || PLL_BIT >= STAT_W) begin : g_bad_bit
         $error("status bit index outside the status word");
      end
      if (LOCK_MASK[ANA_BIT] || LOCK_MASK[PLL_BIT]) begin : g_bad_mask
         $error("lock mask overlaps a timer-expired bit");
      end
   endgenerate

   logic [STAT_W-1:0] lock_hit;

   for (genvar b = 0; b < STAT_W; b++) begin : g_lock
      assign lock_hit[b] = status_i[b] & LOCK_MASK[b];
   end

   assign ok_o = status_i[ANA_BIT] & status_i[PLL_BIT] & ~(|lock_hit);

endmodule

// File: rtl/xcvr_rst_seq.sv
`timescale 1ns/1ps
module xcvr_rst_seq
   import xrs_pkg::*;
#(
   parameter int unsigned CLK_HZ      = 156_250_000,
   parameter int unsigned HOLD_US     = 1000,
   parameter int unsigned SETTLE_US   = 1000,
   parameter int unsigned BOOT_US     = 15000,
   parameter int unsigned LINK_US     = 200,
   parameter int unsigned MAX_TRIES   = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STAT_W      = 8,
   parameter int unsigned ANA_BIT     = 0,
   parameter int unsigned PLL_BIT     = 1,
   parameter logic [STAT_W-1:0] LOCK_MASK = 8'hF0
) (
   input  logic              clk,
   input  logic              arst_n,
   input  logic              start_i,
   input  logic              clk_stable_i,
   input  logic [STAT_W-1:0] dev_status_i,
   output logic              dev_rst_n_o,
   output logic              done_o,
   output logic              pass_o
);

   localparam longint unsigned HOLD_CYC   = us_to_cycles(64'(CLK_HZ), 64'(HOLD_US));
   localparam longint unsigned SETTLE_CYC = us_to_cycles(64'(CLK_HZ), 64'(SETTLE_US));
   localparam longint unsigned BOOT_CYC   = us_to_cycles(64'(CLK_HZ), 64'(BOOT_US));
   localparam longint unsigned LINK_CYC   = us_to_cycles(64'(CLK_HZ), 64'(LINK_US));
   localparam longint unsigned MAX_AB = (HOLD_CYC > SETTLE_CYC) ? HOLD_CYC : SETTLE_CYC;
   localparam longint unsigned MAX_CD = (BOOT_CYC > LINK_CYC) ? BOOT_CYC : LINK_CYC;
   localparam longint unsigned MAX_CYC = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
   localparam int unsigned CNT_W = $clog2(MAX_CYC + 1);
   localparam int unsigned TRY_W = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;

   localparam logic [CNT_W-1:0] HOLD_LD   = CNT_W'(HOLD_CYC - 1);
   localparam logic [CNT_W-1:0] SETTLE_LD = CNT_W'(SETTLE_CYC - 1);
   localparam logic [CNT_W-1:0] BOOT_LD   = CNT_W'(BOOT_CYC - 1);
   localparam logic [CNT_W-1:0] LINK_LD   = CNT_W'(LINK_CYC - 1);
   localparam logic [TRY_W-1:0] LAST_TRY  = TRY_W'(MAX_TRIES - 1);

   generate
      if (MAX_TRIES < 1) begin : g_bad_tries
         $error("MAX_TRIES must be at least 1");
      end
      if (HOLD_CYC < 1 || SETTLE_CYC < 1 || BOOT_CYC < 1 || LINK_CYC < 1) begin : g_bad_delay
         $error("every interval must last at least one cycle");
      end
   endgenerate

   // ---- input synchronisation -------------------------------------------
   logic [STAT_W:0]   sync_q;
   logic              clk_ok_s;
   logic [STAT_W-1:0] stat_s;
   logic              stat_ok;

   xrs_sync #(.W(STAT_W + 1), .STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .arst_n (arst_n),
      .d_i    ({clk_stable_i, dev_status_i}),
      .q_o    (sync_q)
   );
   assign {clk_ok_s, stat_s} = sync_q;

   xrs_status_chk #(
      .STAT_W(STAT_W), .ANA_BIT(ANA_BIT), .PLL_BIT(PLL_BIT), .LOCK_MASK(LOCK_MASK)
   ) u_chk (
      .status_i (stat_s),
      .ok_o     (stat_ok)
   );

   // ---- shared interval timer --------------------------------------------
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_exp;

   xrs_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk        (clk),
      .arst_n     (arst_n),
      .load_i     (tmr_load),
      .load_val_i (tmr_val),
      .expired_o  (tmr_exp)
   );

   // ---- sequencing -------------------------------------------------------
   seq_state_e       state_q, state_d;
   logic [TRY_W-1:0] tries_q, tries_d;
   logic             rstn_q, rstn_d;
   logic             done_q, done_d;
   logic             pass_q, pass_d;

   always_comb begin
      state_d  = state_q;
      tries_d  = tries_q;
      rstn_d   = rstn_q;
      pass_d   = pass_q;
      done_d   = 1'b0;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (state_q)
         ST_IDLE: if (start_i) begin
            state_d  = ST_HOLD;
            tries_d  = '0;
            rstn_d   = 1'b0;
            pass_d   = 1'b0;
            tmr_load = 1'b1;
            tmr_val  = HOLD_LD;
         end
         ST_HOLD: if (tmr_exp) state_d = ST_WAIT_CLK;
         ST_WAIT_CLK: if (clk_ok_s) begin
            state_d  = ST_SETTLE;
            tmr_load = 1'b1;
            tmr_val  = SETTLE_LD;
         end
         ST_SETTLE: if (tmr_exp) begin
            state_d  = ST_BOOT;
            rstn_d   = 1'b1;
            tmr_load = 1'b1;
            tmr_val  = BOOT_LD;
         end
         ST_BOOT: if (tmr_exp) begin
            state_d  = ST_LINK;
            tmr_load = 1'b1;
            tmr_val  = LINK_LD;
         end
         ST_LINK: if (tmr_exp) state_d = ST_CHECK;
         ST_CHECK: begin
            if (stat_ok) begin
               state_d = ST_IDLE;
               done_d  = 1'b1;
               pass_d  = 1'b1;
            end else if (tries_q == LAST_TRY) begin
               state_d = ST_IDLE;
               done_d  = 1'b1;
               pass_d  = 1'b0;
            end else begin
               state_d  = ST_HOLD;
               tries_d  = tries_q + 1'b1;
               rstn_d   = 1'b0;
               tmr_load = 1'b1;
               tmr_val  = HOLD_LD;
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         state_q <= ST_IDLE;
         tries_q <= '0;
         rstn_q  <= 1'b0;
         done_q  <= 1'b0;
         pass_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         tries_q <= tries_d;
         rstn_q  <= rstn_d;
         done_q  <= done_d;
         pass_q  <= pass_d;
      end
   end

   assign dev_rst_n_o = rstn_q;
   assign done_o      = done_q;
   assign pass_o      = pass_q;

   // ---- assertions -------------------------------------------------------
   AST_START_GRABS_LINE: assert property (@(posedge clk) disable iff (!arst_n)
      (state_q == ST_IDLE && start_i) |=> (!dev_rst_n_o && !pass_o)); // R2
   AST_RELEASE_AFTER_SETTLE: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(dev_rst_n_o) |-> ($past(state_q) == ST_SETTLE)); // R3
   AST_CHECK_AFTER_LINK: assert property (@(posedge clk) disable iff (!arst_n)
      (state_q == ST_CHECK) |-> ($past(state_q) == ST_LINK)); // R4
   AST_PASS_NEEDS_GOOD_STATUS: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(pass_o) |-> $past(stat_ok)); // R5
   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!arst_n)
      done_o |=> !done_o); // R6
   AST_PASS_HELD_IN_IDLE: assert property (@(posedge clk) disable iff (!arst_n)
      (state_q == ST_IDLE && !start_i) |=> $stable(pass_o)); // R6
   AST_TRIES_BOUNDED: assert property (@(posedge clk) disable iff (!arst_n)
      (state_q != ST_IDLE) |-> (32'(tries_q) < MAX_TRIES)); // R7
   AST_FAIL_LEAVES_RELEASED: assert property (@(posedge clk) disable iff (!arst_n)
      (done_o && !pass_o) |-> dev_rst_n_o); // R8
   AST_BUSY_IGNORES_START: assert property (@(posedge clk) disable iff (!arst_n)
      ((state_q == ST_BOOT || state_q == ST_LINK) && start_i) |=> dev_rst_n_o); // R9

endmodule

// File: tb/sim_xcvr_rst_seq.sv
`timescale 1ns/1ps
module sim_xcvr_rst_seq;

   localparam int CLK_PERIOD = 10;
   localparam int unsigned B_HZ = 123_457;
   localparam int SYNC = 2;
   localparam int MAXT = 3;
   localparam int WATCHDOG = 150_000;

   function automatic int cyc(longint unsigned us);
      return int'((longint'(B_HZ) * us + 999_999) / 1_000_000);
   endfunction

   localparam int T_A = (B_HZ * 64'd1000 + 999_999) / 1_000_000;
   int t_a, t_s, t_b, t_l;

   logic       clk = 1'b0;
   logic       arst_n = 1'b0;
   logic       start_i = 1'b0;
   logic       clk_stable_i = 1'b1;
   logic [7:0] dev_status_i = 8'h03;
   logic       dev_rst_n_o, done_o, pass_o;

   xcvr_rst_seq #(.CLK_HZ(B_HZ), .SYNC_STAGES(SYNC), .MAX_TRIES(MAXT)) u0 (
      .clk(clk), .arst_n(arst_n), .start_i(start_i), .clk_stable_i(clk_stable_i),
      .dev_status_i(dev_status_i), .dev_rst_n_o(dev_rst_n_o), .done_o(done_o), .pass_o(pass_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   int  checks = 0, errors = 0, cycles = 0;
   bit  finished = 1'b0;
   bit  cmp_en = 1'b0;
   logic exp_rst = 1'b0, exp_done = 1'b0, exp_pass = 1'b0;

   // history of driven inputs, one entry per rising edge
   logic [8:0] hist[$];
   always @(posedge clk) begin
      hist.push_back({clk_stable_i, dev_status_i});
      if (hist.size() > 16) void'(hist.pop_front());
   end

   function automatic logic [8:0] seen();
      return hist[hist.size() - 1 - SYNC];
   endfunction

   function automatic bit good(logic [7:0] s);
      return s[0] && s[1] && ((s & 8'hF0) == 8'h00);
   endfunction

   task automatic chk(bit ok, string tag, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
      end
   endtask

   // every-cycle comparison against the reference model
   always @(negedge clk) begin
      if (cmp_en && !finished) begin
         checks++;
         if (dev_rst_n_o !== exp_rst || done_o !== exp_done || pass_o !== exp_pass) begin
            errors++;
            $display("FAIL R3,R4,R6 cycle %0d actual rst/done/pass=%b%b%b expected=%b%b%b",
                     cycles, dev_rst_n_o, done_o, pass_o, exp_rst, exp_done, exp_pass);
         end
      end
   end

   // reset-line width monitor
   bit mon_clr = 1'b0;
   logic prev_rst = 1'b0;
   int low_len = 0, hi_len = 0, last_low = 0, last_hi = 0, n_rel = 0;
   always @(negedge clk) begin
      if (mon_clr) begin
         low_len = 0; hi_len = 0; n_rel = 0; mon_clr = 1'b0;
      end
      if (!prev_rst && dev_rst_n_o) begin
         last_low = low_len; hi_len = 0; n_rel++;
      end
      if (prev_rst && !dev_rst_n_o) low_len = 0;
      if (done_o) last_hi = hi_len;
      if (dev_rst_n_o) hi_len++; else low_len++;
      prev_rst = dev_rst_n_o;
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !finished) begin
         finished = 1'b1;
         errors++; checks++;
         $display("FAIL watchdog actual=%0d expected<%0d", cycles, WATCHDOG);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   // reference model: one run from a start request to its done pulse
   task automatic run_seq();
      int tries;
      @(negedge clk);
      start_i = 1'b1;
      step();
      start_i = 1'b0;
      exp_rst = 1'b0; exp_pass = 1'b0; exp_done = 1'b0;
      mon_clr = 1'b1;
      @(negedge clk);
      chk(!dev_rst_n_o && !pass_o, "R2 line low and result cleared after start",
          {dev_rst_n_o, pass_o}, 0);
      tries = 0;
      forever begin
         tries++;
         repeat (t_a) step();
         do step(); while (!seen()[8]);
         repeat (t_s) step();
         exp_rst = 1'b1;
         repeat (t_b + t_l) step();
         step();
         if (good(seen()[7:0])) begin
            exp_done = 1'b1; exp_pass = 1'b1;
            step(); exp_done = 1'b0;
            return;
         end else if (tries == MAXT) begin
            exp_done = 1'b1; exp_pass = 1'b0;
            step(); exp_done = 1'b0;
            return;
         end else begin
            exp_rst = 1'b0;
         end
      end
   endtask

   task automatic fail_case(logic [7:0] st, string tag);
      dev_status_i = st;
      run_seq();
      @(negedge clk);
      chk(n_rel == MAXT, {tag, " attempts on persistent bad status"}, n_rel, MAXT);
      chk(!pass_o && dev_rst_n_o, {"R8 released and failed after ", tag}, {pass_o, dev_rst_n_o}, 1);
   endtask

   initial begin
      t_a = cyc(1000); t_s = cyc(1000); t_b = cyc(15000); t_l = cyc(200);

      // R1: reset state
      repeat (3) @(negedge clk);
      chk(!dev_rst_n_o && !done_o && !pass_o, "R1 outputs during reset",
          {dev_rst_n_o, done_o, pass_o}, 0);
      arst_n = 1'b1;
      cmp_en = 1'b1;
      repeat (30) @(negedge clk);
      chk(!dev_rst_n_o && !done_o && !pass_o, "R1 outputs idle before start",
          {dev_rst_n_o, done_o, pass_o}, 0);

      // R10: rounding of the intervals
      chk(t_a == 124 && T_A == 124, "R10 hold interval rounded up", t_a, 124);
      chk(t_b == 1852, "R10 boot interval rounded up", t_b, 1852);
      chk(t_l == 25, "R10 link interval rounded up", t_l, 25);

      // R3 R4 R6: clean pass
      dev_status_i = 8'h03;
      run_seq();
      @(negedge clk);
      chk(last_low == t_a + 1 + t_s, "R3 low width with clocks already stable", last_low, t_a + 1 + t_s);
      chk(last_hi == t_b + t_l + 1, "R4 release to evaluation", last_hi, t_b + t_l + 1);
      chk(n_rel == 1, "R6 single attempt on good status", n_rel, 1);
      repeat (50) @(negedge clk);
      chk(pass_o && dev_rst_n_o && !done_o, "R6 result held in idle", {pass_o, dev_rst_n_o, done_o}, 6);

      // R5: don't-care bits do not spoil a pass
      dev_status_i = 8'h0F;
      run_seq();
      @(negedge clk);
      chk(pass_o && n_rel == 1, "R5 bits 3:2 ignored", n_rel, 1);

      // R5 R8: each failing condition exhausts the attempts
      fail_case(8'h02, "R5 analog timer missing,R7");
      fail_case(8'h01, "R5 pll timer missing,R7");
      fail_case(8'h13, "R5 lock loss bit 4,R7");

      // R7: first attempt fails, second passes
      dev_status_i = 8'h83;
      fork
         run_seq();
         begin
            repeat (t_a + 1 + t_s + t_b + t_l + 300) @(negedge clk);
            dev_status_i = 8'h03;
         end
      join
      @(negedge clk);
      chk(n_rel == 2 && pass_o, "R7 retry then pass", n_rel, 2);

      // R3: late clock-stable lengthens the low period
      clk_stable_i = 1'b0;
      fork
         run_seq();
         begin
            repeat (400) @(negedge clk);
            clk_stable_i = 1'b1;
         end
      join
      @(negedge clk);
      chk(last_low > t_a + t_s + 1, "R3 low period waits for clocks", last_low, t_a + t_s + 1);
      chk(pass_o, "R3 run completes after late clocks", pass_o, 1);

      // R9: start pulses mid-run are ignored
      fork
         run_seq();
         begin
            repeat (60) @(negedge clk);
            start_i = 1'b1; @(negedge clk); start_i = 1'b0;
            repeat (1000) @(negedge clk);
            start_i = 1'b1; @(negedge clk); start_i = 1'b0;
         end
      join
      @(negedge clk);
      chk(n_rel == 1 && pass_o, "R9 extra starts ignored", n_rel, 1);

      repeat (10) @(negedge clk);
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule